// File: doc/BRIEF.md
# Audio Ring-Buffer DMA Reader

This block streams audio sample data from a circular region of memory into a local FIFO that feeds a serial audio transmitter. Software chooses a base address and an inclusive last-word address for the region, points the read pointer at the base, and then enables fetching and draining. The reader issues fixed 128-byte bursts (sixteen 64-bit beats) over a simple request/grant/data-valid memory interface. It requests a burst only when the FIFO can take all of it. After the burst that covers the last-word address, the reader returns to the base.

The serializer pulls words with a valid/ready handshake. The current read pointer is visible at all times, so software can track the playback position. When drain is enabled and the serializer asks for a word from an empty FIFO, a sticky underrun flag is set. A level-sensitive init input parks the reader at the base address with an empty FIFO; releasing it leaves that state in place. A soft-reset pulse discards the FIFO and any burst in progress, but keeps the pointer.

Top module: `audio_ring_reader`

## Requirements
- R1: After reset, mem_req, out_valid and underrun are 0 and rd_ptr is 0.
- R2: While init_req is 1, rd_ptr is loaded from cfg_base_addr, the FIFO is emptied, mem_req stays 0 and underrun is cleared. After init_req falls, rd_ptr still equals the base.
- R3: mem_req rises only when fill_en and fifo_en are 1 and the FIFO holds at most FIFO_DEPTH-16 words. Once raised, it stays high with a stable mem_addr until mem_gnt, unless init_req or soft_rst aborts it.
- R4: Each granted burst takes exactly 16 mem_rvalid beats. Beat k is the word at mem_addr+8k. Words leave on out_data in memory order, and the FIFO never accepts a word while full.
- R5: rd_ptr changes only on init, on a pointer write, or on the last beat of a burst. On that beat it becomes cfg_base_addr if rd_ptr+120 >= cfg_last_addr, and rd_ptr+128 otherwise.
- R6: out_valid is 1 only when drain_en and fifo_en are 1 and the FIFO is not empty. A word is removed when out_valid and out_ready are both 1.
- R7: Clearing fill_en stops new requests, but a burst that was already granted completes all 16 beats.
- R8: While fifo_en is 0, the FIFO is held empty and out_valid is 0. Words held before fifo_en fell are discarded.
- R9: underrun is set when drain_en, fifo_en and out_ready are 1 and the FIFO is empty. It then stays set until soft_rst or init_req.
- R10: A soft_rst pulse empties the FIFO, clears underrun and returns the fetcher to idle, leaving rd_ptr unchanged.
- R11: ptr_wr, when the fetcher is idle and init_req is 0, loads rd_ptr with ptr_wr_addr. Streaming then starts from that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_base_addr | input | ADDR_W | Byte address of the first word of the ring |
| cfg_last_addr | input | ADDR_W | Byte address of the last 64-bit word of the ring (inclusive) |
| ptr_wr | input | 1 | Load strobe for the read pointer |
| ptr_wr_addr | input | ADDR_W | Value loaded by ptr_wr |
| init_req | input | 1 | Level: park at base with empty FIFO |
| soft_rst | input | 1 | Pulse: flush FIFO, clear underrun, abort burst |
| fill_en | input | 1 | Allow memory-to-FIFO fetches |
| drain_en | input | 1 | Allow FIFO-to-serializer transfers |
| fifo_en | input | 1 | FIFO enable; 0 holds it empty |
| mem_req | output | 1 | Burst request |
| mem_addr | output | ADDR_W | Burst start address |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | DATA_W | Read beat data |
| out_valid | output | 1 | Word available to serializer |
| out_data | output | DATA_W | Word to serializer |
| out_ready | input | 1 | Serializer takes a word |
| rd_ptr | output | ADDR_W | Current read pointer |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The embedded properties check several rules on every cycle. A request is held with a steady address until granted. A request never goes out without room for a full burst, and the FIFO never overflows. out_valid never rises while drain or the FIFO is disabled. underrun holds once set. The pointer moves only on init, a write, or a burst's last beat. Only the bench scenarios can show the rest. These are word order across wraps for rings of one to three bursts, the exact pointer value after fetching stops, and completion of a burst whose fill enable was withdrawn. They also cover the flush behaviour of fifo_en, init and soft reset, and the restart from a written pointer.

// File: rtl/arr_pkg.sv
package arr_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_RECV = 2'd2
  } fetch_state_e;
endpackage

// File: rtl/arr_fifo.sv
module arr_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 rd_data,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp, wp_n, rp_n;
  logic [LW-1:0] cnt, cnt_n;
  logic          wr_en;

  assign wr_en = push && !flush;

  always_comb begin
    wp_n  = wp;
    rp_n  = rp;
    cnt_n = cnt;
    if (flush) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end else begin
      wp_n  = wp + AW'(push);
      rp_n  = rp + AW'(pop);
      cnt_n = cnt + LW'(push) - LW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp_n;
      rp  <= rp_n;
      cnt <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= push_data;
  end

  assign rd_data = mem[rp];
  assign empty   = (cnt == '0);
  assign full    = (cnt == LW'(DEPTH));
  assign level   = cnt;

  // R4: a full FIFO is never written
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush) |-> !full);

  // R6: a word is only removed when one is present
  p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !flush) |-> !empty);
endmodule

// File: rtl/arr_fetch.sv
module arr_fetch
  import arr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BEATS      = 16,
  parameter int WORD_BYTES = 8,
  parameter int DEPTH      = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        soft_rst,
  input  logic                        init,
  input  logic                        fill_en,
  input  logic                        fifo_en,
  input  logic [ADDR_W-1:0]           base_addr,
  input  logic [ADDR_W-1:0]           last_addr,
  input  logic                        ptr_load,
  input  logic [ADDR_W-1:0]           ptr_value,
  input  logic [$clog2(DEPTH+1)-1:0]  level,
  input  logic                        mem_gnt,
  input  logic                        mem_rvalid,
  output logic                        mem_req,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic                        push,
  output logic [ADDR_W-1:0]           rd_ptr
);
  localparam int LW          = $clog2(DEPTH+1);
  localparam int BW          = $clog2(BEATS);
  localparam int BURST_BYTES = BEATS * WORD_BYTES;
  localparam int SPACE_LIM   = DEPTH - BEATS;

  fetch_state_e      st, st_n;
  logic [ADDR_W-1:0] ptr_n;
  logic [BW-1:0]     beat, beat_n;
  logic              room_ok, last_beat, wraps, st_en;

  assign room_ok   = (level <= LW'(SPACE_LIM));
  assign last_beat = (st == FS_RECV) && mem_rvalid && (beat == BW'(BEATS-1));
  assign wraps     = (rd_ptr + ADDR_W'(BURST_BYTES - WORD_BYTES)) >= last_addr;

  always_comb begin
    st_n   = st;
    ptr_n  = rd_ptr;
    beat_n = beat;
    push   = 1'b0;
    unique case (st)
      FS_IDLE: if (fill_en && fifo_en && room_ok) st_n = FS_REQ;
      FS_REQ: if (mem_gnt) begin
        st_n   = FS_RECV;
        beat_n = '0;
      end
      FS_RECV: if (mem_rvalid) begin
        push   = 1'b1;
        beat_n = beat + BW'(1);
        if (beat == BW'(BEATS-1)) begin
          st_n  = FS_IDLE;
          ptr_n = wraps ? base_addr : rd_ptr + ADDR_W'(BURST_BYTES);
        end
      end
      default: st_n = FS_IDLE;
    endcase
    if (ptr_load && st == FS_IDLE) ptr_n = ptr_value;
    if (soft_rst) begin
      st_n  = FS_IDLE;
      push  = 1'b0;
      ptr_n = rd_ptr;
    end
    if (init) begin
      st_n  = FS_IDLE;
      push  = 1'b0;
      ptr_n = base_addr;
    end
  end

  assign st_en = (st_n != st) || (beat_n != beat) || (ptr_n != rd_ptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= FS_IDLE;
      beat   <= '0;
      rd_ptr <= '0;
    end else if (st_en) begin
      st     <= st_n;
      beat   <= beat_n;
      rd_ptr <= ptr_n;
    end
  end

  assign mem_req  = (st == FS_REQ);
  assign mem_addr = rd_ptr;

  // R3: request held with steady address until granted
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !init && !soft_rst) |=> (mem_req && $stable(mem_addr)));

  // R3: room for a whole burst whenever a request is out
  p_req_space_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (level <= LW'(SPACE_LIM)));

  // R5: pointer moves only on init, write, or final beat
  p_ptr_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_ptr) |-> $past(init || (ptr_load && st == FS_IDLE) || last_beat));
endmodule

// File: rtl/audio_ring_reader.sv
module audio_ring_reader #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 64,
  parameter int BURST_BYTES = 128,
  parameter int FIFO_DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base_addr,
  input  logic [ADDR_W-1:0] cfg_last_addr,
  input  logic              ptr_wr,
  input  logic [ADDR_W-1:0] ptr_wr_addr,
  input  logic              init_req,
  input  logic              soft_rst,
  input  logic              fill_en,
  input  logic              drain_en,
  input  logic              fifo_en,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic              underrun
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int BEATS      = BURST_BYTES / WORD_BYTES;
  localparam int LW         = $clog2(FIFO_DEPTH+1);

  logic          rst_q1, rst_s;
  logic          push, pop, flush, f_empty, f_full;
  logic [LW-1:0] f_level;
  logic          urun_n, urun_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_s  <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_s  <= rst_q1;
    end
  end

  assign flush     = soft_rst || init_req || !fifo_en;
  assign out_valid = fifo_en && drain_en && !f_empty;
  assign pop       = out_valid && out_ready;

  arr_fetch #(
    .ADDR_W(ADDR_W), .BEATS(BEATS), .WORD_BYTES(WORD_BYTES), .DEPTH(FIFO_DEPTH)
  ) u_fetch (
    .clk(clk), .rst_n(rst_s), .soft_rst(soft_rst), .init(init_req),
    .fill_en(fill_en), .fifo_en(fifo_en),
    .base_addr(cfg_base_addr), .last_addr(cfg_last_addr),
    .ptr_load(ptr_wr), .ptr_value(ptr_wr_addr), .level(f_level),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_req(mem_req), .mem_addr(mem_addr), .push(push), .rd_ptr(rd_ptr)
  );

  arr_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_s), .flush(flush), .push(push), .push_data(mem_rdata),
    .pop(pop), .rd_data(out_data), .empty(f_empty), .full(f_full), .level(f_level)
  );

  always_comb begin
    urun_n = underrun;
    if (soft_rst || init_req)
      urun_n = 1'b0;
    else if (drain_en && fifo_en && out_ready && f_empty)
      urun_n = 1'b1;
  end
  assign urun_en = (urun_n != underrun);

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)       underrun <= 1'b0;
    else if (urun_en) underrun <= urun_n;
  end

  // R6: nothing offered while drain or FIFO disabled
  p_out_gate_r6: assert property (@(posedge clk) disable iff (!rst_s)
    out_valid |-> (drain_en && fifo_en));

  // R9: underrun holds until cleared
  p_underrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_s)
    (underrun && !soft_rst && !init_req) |=> underrun);

  // R8: disabled FIFO is empty one cycle later
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_s)
    !fifo_en |=> (f_empty && !f_full));
endmodule

// File: tb/audio_ring_reader_bench.sv
module audio_ring_reader_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cfg_base_addr, cfg_last_addr, ptr_wr_addr;
  logic        ptr_wr, init_req, soft_rst, fill_en, drain_en, fifo_en;
  logic        mem_req, mem_gnt, mem_rvalid, out_valid, out_ready, underrun;
  logic [31:0] mem_addr, rd_ptr;
  logic [63:0] mem_rdata, out_data;

  int checks = 0;
  int failures = 0;
  int grants = 0;
  int beats = 0;
  int gnt_dly = 0;
  bit gap_mode = 1'b0;

  always #2.5 clk = ~clk;

  audio_ring_reader u_audio_ring_reader (
    .clk(clk), .rst_n(rst_n), .cfg_base_addr(cfg_base_addr), .cfg_last_addr(cfg_last_addr),
    .ptr_wr(ptr_wr), .ptr_wr_addr(ptr_wr_addr), .init_req(init_req), .soft_rst(soft_rst),
    .fill_en(fill_en), .drain_en(drain_en), .fifo_en(fifo_en),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .rd_ptr(rd_ptr), .underrun(underrun)
  );

  function automatic logic [63:0] word_of(input logic [31:0] a);
    return {a, a ^ 32'hA5A5_5A5A};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // counters at the active edge, from ports only
  always @(posedge clk) begin
    if (mem_req && mem_gnt) grants <= grants + 1;
    if (mem_rvalid) beats <= beats + 1;
  end

  // memory responder
  initial begin
    bit active = 0;
    bit phase = 0;
    int bcnt = 0;
    int dcnt = 0;
    logic [31:0] baddr = '0;
    mem_gnt = 0; mem_rvalid = 0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_gnt = 0;
      mem_rvalid = 0;
      if (active) begin
        if (gap_mode && phase) phase = 0;
        else begin
          phase = 1;
          mem_rvalid = 1;
          mem_rdata = word_of(baddr + 32'(bcnt * 8));
          bcnt++;
          if (bcnt == 16) active = 0;
        end
      end else if (mem_req) begin
        if (dcnt < gnt_dly) dcnt++;
        else begin
          dcnt = 0; mem_gnt = 1; baddr = mem_addr; active = 1; bcnt = 0; phase = 0;
        end
      end
    end
  end

  task automatic park(input logic [31:0] base, input int nb);
    fill_en = 0; drain_en = 0; out_ready = 0;
    cyc(60);
    cfg_base_addr = base;
    cfg_last_addr = base + 32'(nb * 128) - 32'd8;
    init_req = 1;
    cyc(2);
    init_req = 0;
    fifo_en = 1;
    cyc(1);
  endtask

  // stream nwords, check order; returns number of grants in this run
  task automatic stream(input logic [31:0] base, input int nb, input int first,
                        input int nwords, input int rmode, output int g_used);
    int k = 0;
    int t = 0;
    int g0 = grants;
    int ring = nb * 16;
    fill_en = 1; drain_en = 1;
    while (k < nwords && t < 4000) begin
      @(negedge clk);
      out_ready = (rmode == 0) ? 1'b1 : ((t % 3) != 0);
      #0.5;
      if (out_valid && out_ready) begin
        logic [31:0] ea;
        ea = base + 32'(((first + k) % ring) * 8);
        chk(out_data == word_of(ea), "R4 word order/wrap R5", out_data, word_of(ea));
        k++;
      end
      t++;
    end
    chk(k == nwords, "R4 stream completed", 64'(k), 64'(nwords));
    @(negedge clk);
    out_ready = 0; fill_en = 0;
    cyc(80);
    g_used = grants - g0;
  endtask

  initial begin
    int g;
    int g0;
    int b0;
    logic [31:0] keep;
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int g, g0, b0;
    logic [31:0] keep;
    rst_n = 0; cfg_base_addr = '0; cfg_last_addr = '0; ptr_wr = 0; ptr_wr_addr = '0;
    init_req = 0; soft_rst = 0; fill_en = 0; drain_en = 0; fifo_en = 0; out_ready = 0;
    cyc(4);
    rst_n = 1;
    cyc(4);
    // R1
    chk(mem_req == 0 && out_valid == 0 && underrun == 0, "R1 reset outputs",
        {mem_req, out_valid, underrun}, 0);
    chk(rd_ptr == 0, "R1 reset pointer", rd_ptr, 0);

    // R2
    cfg_base_addr = 32'h1000; cfg_last_addr = 32'h10F8; init_req = 1;
    cyc(2);
    chk(rd_ptr == 32'h1000 && mem_req == 0, "R2 init loads base", rd_ptr, 32'h1000);
    init_req = 0;
    cyc(3);
    chk(rd_ptr == 32'h1000, "R2 base kept after init release", rd_ptr, 32'h1000);

    // R3 / R6: fill with drain off: exactly two bursts fit in 32 words
    fifo_en = 1; fill_en = 1; drain_en = 0; out_ready = 1;
    g0 = grants;
    cyc(120);
    chk(grants - g0 == 2, "R3 bursts limited by space", 64'(grants - g0), 2);
    chk(mem_req == 0, "R3 no request when full", mem_req, 0);
    chk(out_valid == 0 && underrun == 0, "R6 no output with drain off", {out_valid, underrun}, 0);

    // R8: FIFO disable discards contents
    fill_en = 0; out_ready = 0; drain_en = 1;
    cyc(1);
    chk(out_valid == 1, "R6 output once drain on", out_valid, 1);
    fifo_en = 0;
    cyc(1);
    chk(out_valid == 0, "R8 no output with fifo off", out_valid, 0);
    fifo_en = 1;
    cyc(1);
    chk(out_valid == 0 && mem_req == 0, "R8 contents discarded", {out_valid, mem_req}, 0);

    // R9 / R10
    out_ready = 1;
    cyc(1);
    chk(underrun == 1, "R9 underrun on empty read", underrun, 1);
    out_ready = 0;
    cyc(4);
    chk(underrun == 1, "R9 underrun sticky", underrun, 1);
    keep = rd_ptr;
    soft_rst = 1;
    cyc(1);
    soft_rst = 0;
    cyc(1);
    chk(underrun == 0, "R10 soft reset clears underrun", underrun, 0);
    chk(rd_ptr == keep, "R10 pointer kept", rd_ptr, keep);
    out_ready = 1;
    cyc(1);
    chk(underrun == 1, "R9 sets again", underrun, 1);
    out_ready = 0;
    init_req = 1;
    cyc(1);
    init_req = 0;
    cyc(1);
    chk(underrun == 0, "R2 R9 init clears underrun", underrun, 0);

    // R7: withdraw fill right after a grant
    park(32'h3000, 2);
    g0 = grants; b0 = beats;
    fill_en = 1;
    while (grants == g0) @(negedge clk);
    fill_en = 0;
    cyc(60);
    chk(beats - b0 == 16, "R7 granted burst completes", 64'(beats - b0), 16);
    chk(grants - g0 == 1 && mem_req == 0, "R7 no new request", 64'(grants - g0), 1);
    chk(rd_ptr == 32'h3080, "R5 pointer after one burst", rd_ptr, 32'h3080);

    // R11: pointer write then stream from it
    park(32'h1000, 2);
    ptr_wr_addr = 32'h1080; ptr_wr = 1;
    cyc(1);
    ptr_wr = 0;
    chk(rd_ptr == 32'h1080, "R11 pointer write", rd_ptr, 32'h1080);
    stream(32'h1000, 2, 16, 40, 0, g);
    chk(rd_ptr == 32'h1000 + 32'(((1 + g) % 2) * 128), "R11 R5 pointer after run",
        rd_ptr, 32'h1000 + 32'(((1 + g) % 2) * 128));

    // sweep: ring size, memory pacing, consumer pacing
    for (int nb = 1; nb <= 3; nb++)
      for (int gm = 0; gm < 2; gm++)
        for (int rm = 0; rm < 2; rm++) begin
          logic [31:0] base;
          base = 32'(nb) * 32'h1_0000 + 32'(gm * 128);
          gap_mode = gm[0];
          gnt_dly = gm * 2;
          park(base, nb);
          stream(base, nb, 0, nb * 32 + 5, rm, g);
          chk(rd_ptr == base + 32'((g % nb) * 128), "R5 pointer after sweep run",
              rd_ptr, base + 32'((g % nb) * 128));
        end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule